// File: doc/BRIEF.md
# Coin Credit Dispense Controller

This block tracks credit for a single coin slot that takes two coin kinds: a small coin worth 5 cents and a large coin worth 10 cents. Each coin arrives as a one-cycle flag on its own input. Once the accumulated credit reaches 15 cents or more, the block raises a release output. The output is a Moore output, so it depends only on the stored credit and never directly on the coin inputs.

The credit is held in two flip-flops with four levels: empty, 5, 10, and full. Full covers every amount of 15 cents or more. The block gives no change, and any credit above 15 cents is lost. After it reaches full, the block stays full and keeps the release output high until a synchronous reset returns it to empty.

Both coin flags high in the same cycle is an input the block does not have to handle. The surrounding logic must never drive it.

Top module: `coin_credit_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the credit to empty, and `open_o` is 0 in the cycle after the reset clock edge. Reset also clears any partial credit, so three small coins are needed again afterwards.
- R2: Starting from empty, three small coins on `nickel_i` raise `open_o` after the clock edge that samples the third coin. `open_o` stays 0 after the first and second coins.
- R3: From empty, a small coin followed by a large coin raises `open_o`.
- R4: From empty, a large coin followed by a small coin raises `open_o`.
- R5: From empty, two large coins raise `open_o`. The 5 cents above the price are discarded.
- R6: From empty, two small coins followed by one large coin raise `open_o`.
- R7: A cycle with neither coin flag high leaves the credit unchanged, whatever the number of idle cycles between coins.
- R8: Once `open_o` is 1, it stays 1 through any further coins and idle cycles until reset.
- R9: `open_o` changes only on a clock edge. While the completing coin is presented, and before the edge that samples it, `open_o` keeps its old value 0.
- R10: A single coin of either kind never raises `open_o`, and two small coins alone do not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the credit updates on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset to empty credit |
| nickel_i | input | 1 | One-cycle flag: a 5-cent coin was inserted |
| dime_i | input | 1 | One-cycle flag: a 10-cent coin was inserted |
| open_o | output | 1 | High while the credit is 15 cents or more |

## Verification
The hardest condition to see from the ports is a partial credit that is held across idle cycles. The 5-cent and 10-cent levels look identical at `open_o`: both show 0. The stimulus therefore places long idle gaps between coins and then sends exactly the coin that should complete the price. It checks that the output rises on that edge and not one edge earlier or later. The same approach, with a reset in the middle of a sequence, shows that partial credit is cleared and not kept.

// File: rtl/coin_credit_pkg.sv
package coin_credit_pkg;

    localparam int NICKEL_CENTS = 5;
    localparam int DIME_CENTS   = 10;
    localparam int PRICE_CENTS  = 15;
    localparam int CREDIT_W     = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_FULL = 2'b11
    } credit_e;

    typedef struct packed {
        logic nickel;
        logic dime;
    } coin_s;

    function automatic int credit_to_cents(input credit_e c);
        case (c)
            CR_FIVE: return NICKEL_CENTS;
            CR_TEN:  return DIME_CENTS;
            CR_FULL: return PRICE_CENTS;
            default: return 0;
        endcase
    endfunction

    function automatic credit_e cents_to_credit(input int cents);
        if (cents >= PRICE_CENTS)       return CR_FULL;
        else if (cents >= DIME_CENTS)   return CR_TEN;
        else if (cents >= NICKEL_CENTS) return CR_FIVE;
        else                            return CR_ZERO;
    endfunction

endpackage

// File: rtl/coin_sampler.sv
module coin_sampler
    import coin_credit_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_s coin_o
);
    always_comb begin
        coin_o.nickel = nickel_i;
        coin_o.dime   = dime_i;
    end
endmodule

// File: rtl/credit_next.sv
module credit_next
    import coin_credit_pkg::*;
#(
    parameter bit SOP_FORM = 1'b1
)(
    input  credit_e cur_i,
    input  coin_s   coin_i,
    output credit_e next_o
);
    generate
        if (SOP_FORM) begin : g_sop
            logic q1, q0, n, d, d1, d0;
            always_comb begin
                q1 = cur_i[1];
                q0 = cur_i[0];
                n  = coin_i.nickel;
                d  = coin_i.dime;
                d1 = q1 | d | (q0 & n);
                d0 = (~n & q0) | (~q0 & n) | (q1 & n) | (q1 & d);
                next_o = credit_e'({d1, d0});
            end
        end else begin : g_arith
            int sum_c;
            always_comb begin
                sum_c = credit_to_cents(cur_i)
                      + (coin_i.nickel ? NICKEL_CENTS : 0)
                      + (coin_i.dime   ? DIME_CENTS   : 0);
                next_o = cents_to_credit(sum_c);
            end
        end
    endgenerate
endmodule

// File: rtl/credit_reg.sv
module credit_reg
    import coin_credit_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  credit_e next_i,
    output credit_e credit_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) credit_o <= CR_ZERO;
        else       credit_o <= next_i;
    end
endmodule

// File: rtl/coin_credit_ctrl.sv
module coin_credit_ctrl
    import coin_credit_pkg::*;
#(
    parameter bit SOP_FORM = 1'b1
)(
    input  logic clk_i,
    input  logic rst_i,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o
);
    coin_s   coin;
    credit_e credit_q;
    credit_e credit_d;

    coin_sampler u_sample (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    credit_next #(.SOP_FORM(SOP_FORM)) u_next (
        .cur_i  (credit_q),
        .coin_i (coin),
        .next_o (credit_d)
    );

    credit_reg u_reg (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .next_i   (credit_d),
        .credit_o (credit_q)
    );

    assign open_o = credit_q[1] & credit_q[0];
endmodule

// File: rtl/coin_credit_chk.sv
module coin_credit_chk
    import coin_credit_pkg::*;
(
    input logic    clk_i,
    input logic    rst_i,
    input logic    nickel_i,
    input logic    dime_i,
    input logic    open_o,
    input credit_e credit_q
);
    p_reset_clears_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (credit_q == CR_ZERO && !open_o));

    p_nickel_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (credit_q == CR_ZERO && nickel_i && !dime_i) |=> credit_q == CR_FIVE);

    p_dime_to_full_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (credit_q == CR_TEN && dime_i && !nickel_i) |=> open_o);

    p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!nickel_i && !dime_i) |=> $stable(credit_q));

    p_sticky_full_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        open_o |=> open_o);

    p_open_needs_coin_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(open_o) |-> $past(nickel_i || dime_i));
endmodule

bind coin_credit_ctrl coin_credit_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .open_o   (open_o),
    .credit_q (credit_q)
);

// File: tb/tb_coin_credit_ctrl.sv
module tb_coin_credit_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic open_w;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    coin_credit_ctrl dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .nickel_i (nickel),
        .dime_i   (dime),
        .open_o   (open_w)
    );

    task automatic chk(input logic exp, input string tag);
        total++;
        if (open_w !== exp) begin
            bad++;
            $display("FAIL %s: open=%b expected %b", tag, open_w, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; nickel = 1'b0; dime = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    // present a coin for one cycle; returns at the negedge after the sampling edge
    task automatic coin(input logic n, input logic d);
        @(negedge clk); nickel = n; dime = d;
        @(negedge clk); nickel = 1'b0; dime = 1'b0;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(1'b0, "R1 after reset");
    endtask

    task automatic t_three_nickels();
        do_reset();
        coin(1, 0); chk(1'b0, "R2 one nickel");
        coin(1, 0); chk(1'b0, "R10 two nickels");
        @(negedge clk); nickel = 1'b1;
        #2 chk(1'b0, "R9 before sampling edge");
        @(negedge clk); nickel = 1'b0;
        chk(1'b1, "R2 third nickel opens");
    endtask

    task automatic t_nickel_dime();
        do_reset();
        coin(1, 0); chk(1'b0, "R3 nickel first");
        coin(0, 1); chk(1'b1, "R3 nickel then dime");
    endtask

    task automatic t_dime_nickel();
        do_reset();
        coin(0, 1); chk(1'b0, "R10 dime alone");
        coin(1, 0); chk(1'b1, "R4 dime then nickel");
    endtask

    task automatic t_two_dimes();
        do_reset();
        coin(0, 1);
        @(negedge clk); dime = 1'b1;
        #2 chk(1'b0, "R9 second dime pending");
        @(negedge clk); dime = 1'b0;
        chk(1'b1, "R5 two dimes");
    endtask

    task automatic t_nn_d();
        do_reset();
        coin(1, 0); coin(1, 0); chk(1'b0, "R6 two nickels");
        coin(0, 1); chk(1'b1, "R6 nickels then dime");
    endtask

    task automatic t_idle_gaps();
        do_reset();
        coin(1, 0); idle(6); chk(1'b0, "R7 five held low");
        coin(1, 0); idle(9); chk(1'b0, "R7 ten held low");
        coin(1, 0); chk(1'b1, "R7 held credit completes");
    endtask

    task automatic t_sticky();
        do_reset();
        coin(0, 1); coin(0, 1);
        coin(1, 0); chk(1'b1, "R8 nickel after full");
        coin(0, 1); chk(1'b1, "R8 dime after full");
        idle(5);    chk(1'b1, "R8 idle after full");
        do_reset(); chk(1'b0, "R1 reset clears full");
    endtask

    task automatic t_single_dime();
        do_reset();
        coin(0, 1); idle(4); chk(1'b0, "R10 lone dime stays low");
    endtask

    task automatic t_reset_mid();
        do_reset();
        coin(1, 0); coin(1, 0);
        do_reset();
        coin(1, 0); chk(1'b0, "R1 partial credit cleared one");
        coin(1, 0); chk(1'b0, "R1 partial credit cleared two");
        coin(1, 0); chk(1'b1, "R1 fresh three nickels");
    endtask

    initial begin
        t_reset();
        t_three_nickels();
        t_nickel_dime();
        t_dime_nickel();
        t_two_dimes();
        t_nn_d();
        t_idle_gaps();
        t_sticky();
        t_single_dime();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule